// File: doc/BRIEF.md
# Interlaced TV Sync and Burst Timing Generator

This block produces the horizontal and vertical timing strobes for an analog television output stage. A pixel counter runs across each line and is gated by a pixel-clock enable. Pixel count 0 is the start of horizontal sync, and every horizontal event is placed by its pixel distance from that point: the sync pulse, the blanking interval and the colour-burst gate.

The vertical counter counts half lines. It advances at the start of each line and at the middle of each line. Vertical sync and equalization windows are placed in half-line units, so the two fields of an interlaced frame can have their pulses half a line apart. In interlaced mode a field identifier alternates between the two fields, and each field uses its own start offsets. In progressive mode only the first field's offsets are used.

All timing inputs are captured into a shadow copy during reset and again at the start of each frame. A change to the programmed values therefore never produces a partial line or field.

Top module: `tv_timing_gen`

## Requirements
- R1: `pix_count` counts from 0 up to `h_total_m1` and then returns to 0. It advances only on clock edges where `pix_en` is 1, and holds its value otherwise.
- R2: `hsync` is 1 exactly while `pix_count` is below `hsync_len`.
- R3: `burst_gate` is 1 exactly while `pix_count` lies in [`burst_start_m1`+1, `burst_start_m1`+1+`burst_len`) and `burst_on` is 1. It stays 0 whenever `burst_on` is 0.
- R4: `hblank` is 0 (active picture) exactly while `pix_count` lies in [`hblank_end_m1`+1, `hblank_start_m1`+1). It is 1 at every other pixel count.
- R5: `half_count` advances by one each time `pix_count` becomes 0 or becomes (`h_total_m1`+1)/2, rounded down. After reaching `field_half_m1` it returns to 0, which ends the field.
- R6: `vsync` is 1 exactly while `half_count` lies in [s+1, s+1+`vsync_len`). Here s is `vsync_start_f1_m1` when `field_id` is 0 and `vsync_start_f2_m1` when `field_id` is 1.
- R7: `equal` follows the same rule as R6, using `equal_len` and the `equal_start_f1_m1`/`equal_start_f2_m1` pair. It stays 0 whenever `equal_on` is 0.
- R8: In interlaced mode (`progressive` = 0), `field_id` inverts at every field end. The value 0 marks the first field and 1 marks the second field.
- R9: In progressive mode (`progressive` = 1), `field_id` stays 0, so only the first-field offsets apply.
- R10: All timing inputs are captured during reset and at each frame start. A frame starts at the end of a field with `field_id` 1 in interlaced mode, and at every field end in progressive mode. A change made at any other time has no effect on the outputs until the next frame start.
- R11: While reset is held, `pix_count` and `half_count` are 0 and `field_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable |
| progressive | input | 1 | 1 selects progressive scan, 0 selects interlaced |
| burst_on | input | 1 | Enables the colour-burst gate |
| equal_on | input | 1 | Enables the equalization strobe |
| h_total_m1 | input | 13 | Pixels per line minus one |
| hsync_len | input | 13 | Horizontal sync width in pixels |
| burst_start_m1 | input | 13 | Burst start after sync start, pixels minus one |
| burst_len | input | 13 | Burst width in pixels |
| hblank_start_m1 | input | 13 | Blanking start after sync start, pixels minus one |
| hblank_end_m1 | input | 13 | Blanking end after sync start, pixels minus one |
| field_half_m1 | input | 11 | Half lines per field minus one |
| vsync_len | input | 11 | Vertical sync width in half lines |
| vsync_start_f1_m1 | input | 7 | First-field vertical sync start, half lines minus one |
| vsync_start_f2_m1 | input | 7 | Second-field vertical sync start, half lines minus one |
| equal_len | input | 7 | Equalization width in half lines |
| equal_start_f1_m1 | input | 7 | First-field equalization start, half lines minus one |
| equal_start_f2_m1 | input | 7 | Second-field equalization start, half lines minus one |
| hsync | output | 1 | Horizontal sync strobe |
| hblank | output | 1 | Horizontal blanking strobe |
| burst_gate | output | 1 | Colour-burst gate |
| vsync | output | 1 | Vertical sync strobe |
| equal | output | 1 | Equalization strobe |
| field_id | output | 1 | Field identifier, 0 for the first field and 1 for the second |
| pix_count | output | 13 | Pixel position within the line |
| half_count | output | 11 | Half-line position within the field |

## Verification
The assertions assume an even line length, so that the mid-line tick falls on a pixel count the pixel counter actually reaches. They also assume that the per-field start offsets stay inside the field's half-line range. The bench only ever programs a 20-pixel line and a 9-half-line field, keeping inside both assumptions. With those values, the expected line, half-line and field positions can be derived arithmetically from the number of enabled pixel edges since reset. The single mid-frame change the bench makes is to the sync width, so the line and field lengths stay fixed across the frame boundary and the same arithmetic remains valid.

// File: rtl/tv_timing_pkg.sv
// Package: shared field encoding and the window-membership helper used by
// both the horizontal and the vertical counters.
// Assumes: positions and lengths fit in 16 bits.
package tv_timing_pkg;

    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;

    // True when pos lies in [start_m1+1, start_m1+1+len).
    function automatic logic in_span(input logic [15:0] pos,
                                     input logic [15:0] start_m1,
                                     input logic [15:0] len);
        logic [16:0] lo;
        logic [16:0] hi;
        lo = {1'b0, start_m1} + 17'd1;
        hi = lo + {1'b0, len};
        return ({1'b0, pos} >= lo) && ({1'b0, pos} < hi);
    endfunction

endpackage

// File: rtl/tv_cfg_shadow.sv
// Module: holds a snapshot of the programmed timing vector.
// It captures the vector while reset is held and again on each frame-start
// pulse, so the counters never see a change partway through a frame.
// Assumes: load is a single-cycle pulse from the vertical counter.
module tv_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_q
);

    // Capture the inputs during reset or at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/tv_hcount.sv
// Module: pixel counter plus the horizontal strobes.
// Pixel 0 is the start of sync. Sync, blanking and burst are decoded from the
// counter without extra registers. The module also emits a tick whenever the
// counter is about to land on 0 or on the mid-line position.
// Assumes: the line length is at least two pixels.
module tv_hcount
    import tv_timing_pkg::*;
#(
    parameter int HW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic [HW-1:0] htotal_m1,
    input  logic [HW-1:0] hs_len,
    input  logic          burst_on,
    input  logic [HW-1:0] burst_start_m1,
    input  logic [HW-1:0] burst_len,
    input  logic [HW-1:0] hblank_start_m1,
    input  logic [HW-1:0] hblank_end_m1,
    output logic [HW-1:0] pix_cnt,
    output logic [HW-1:0] half_pos,
    output logic          half_tick,
    output logic          hsync,
    output logic          hblank,
    output logic          burst_gate
);

    logic [HW-1:0] pix_next;
    logic [HW:0]   line_total;

    // Next pixel position, returning to 0 at the programmed line end.
    always_comb begin
        pix_next   = (pix_cnt >= htotal_m1) ? '0 : pix_cnt + HW'(1);
        line_total = {1'b0, htotal_m1} + (HW+1)'(1);
        half_pos   = line_total[HW:1];
        half_tick  = pix_en && ((pix_next == '0) || (pix_next == half_pos));
    end

    // Pixel counter, advanced only on enabled clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (pix_en) begin
            pix_cnt <= pix_next;
        end
    end

    // Horizontal strobes decoded from the pixel position.
    always_comb begin
        hsync      = pix_cnt < hs_len;
        burst_gate = burst_on && in_span(16'(pix_cnt), 16'(burst_start_m1), 16'(burst_len));
        hblank     = !in_span(16'(pix_cnt), 16'(hblank_end_m1),
                              16'(hblank_start_m1) - 16'(hblank_end_m1));
    end

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_cnt)); // R1

endmodule

// File: rtl/tv_vcount.sv
// Module: half-line counter, field identifier and the vertical strobes.
// The counter steps on each half-line tick. The field ends when the counter
// passes the programmed length. Frame start is flagged so the shadow copy
// can reload.
// Assumes: half_tick arrives from the horizontal counter; pix_cnt and
// half_pos are used only by the checks.
module tv_vcount
    import tv_timing_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 11,
    parameter int OW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_tick,
    input  logic          prog,
    input  logic          equal_on,
    input  logic [VW-1:0] field_half_m1,
    input  logic [VW-1:0] vs_len,
    input  logic [OW-1:0] vs_f1_m1,
    input  logic [OW-1:0] vs_f2_m1,
    input  logic [OW-1:0] eq_len,
    input  logic [OW-1:0] eq_f1_m1,
    input  logic [OW-1:0] eq_f2_m1,
    input  logic [HW-1:0] pix_cnt,
    input  logic [HW-1:0] half_pos,
    output logic [VW-1:0] half_cnt,
    output logic          field_id,
    output logic          frame_load,
    output logic          vsync,
    output logic          equal
);

    field_e        field_q;
    logic          field_wrap;
    logic [OW-1:0] vs_start;
    logic [OW-1:0] eq_start;

    // Field end and frame boundary detection.
    always_comb begin
        field_wrap = half_tick && (half_cnt >= field_half_m1);
        frame_load = field_wrap && (prog || (field_q == FIELD_TWO));
    end

    // Half-line counter and field identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            field_q  <= FIELD_ONE;
        end else if (half_tick) begin
            if (field_wrap) begin
                half_cnt <= '0;
                field_q  <= (prog || (field_q == FIELD_TWO)) ? FIELD_ONE : FIELD_TWO;
            end else begin
                half_cnt <= half_cnt + VW'(1);
            end
        end
    end

    // Vertical strobes; the current field picks its start offsets.
    always_comb begin
        vs_start = (field_q == FIELD_TWO) ? vs_f2_m1 : vs_f1_m1;
        eq_start = (field_q == FIELD_TWO) ? eq_f2_m1 : eq_f1_m1;
        vsync    = in_span(16'(half_cnt), 16'(vs_start), 16'(vs_len));
        equal    = equal_on && in_span(16'(half_cnt), 16'(eq_start), 16'(eq_len));
        field_id = field_q;
    end

    AST_HALF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_cnt) |-> ((pix_cnt == '0) || (pix_cnt == half_pos))); // R5
    AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_id) |-> (half_cnt == '0)); // R8
    AST_PROG_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> (field_id == 1'b0)); // R9
    AST_VSYNC_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (half_cnt != '0)); // R6

endmodule

// File: rtl/tv_timing_gen.sv
// Module: top level of the TV timing generator.
// It packs the timing inputs into one shadow vector and splits the snapshot
// between the horizontal and vertical counters. The frame-start pulse from
// the vertical counter reloads the snapshot.
// Assumes: the inputs stay constant for at least one clock before a frame
// start if they are to be taken.
module tv_timing_gen #(
    parameter int HW = 13,
    parameter int VW = 11,
    parameter int OW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          progressive,
    input  logic          burst_on,
    input  logic          equal_on,
    input  logic [HW-1:0] h_total_m1,
    input  logic [HW-1:0] hsync_len,
    input  logic [HW-1:0] burst_start_m1,
    input  logic [HW-1:0] burst_len,
    input  logic [HW-1:0] hblank_start_m1,
    input  logic [HW-1:0] hblank_end_m1,
    input  logic [VW-1:0] field_half_m1,
    input  logic [VW-1:0] vsync_len,
    input  logic [OW-1:0] vsync_start_f1_m1,
    input  logic [OW-1:0] vsync_start_f2_m1,
    input  logic [OW-1:0] equal_len,
    input  logic [OW-1:0] equal_start_f1_m1,
    input  logic [OW-1:0] equal_start_f2_m1,
    output logic          hsync,
    output logic          hblank,
    output logic          burst_gate,
    output logic          vsync,
    output logic          equal,
    output logic          field_id,
    output logic [HW-1:0] pix_count,
    output logic [VW-1:0] half_count
);

    localparam int CFG_W = 3 + 6 * HW + 2 * VW + 5 * OW;

    logic [CFG_W-1:0] cfg_raw;
    logic [CFG_W-1:0] cfg_s;
    logic             frame_load;
    logic             half_tick;
    logic [HW-1:0]    half_pos;

    logic          s_prog, s_burst_on, s_equal_on;
    logic [HW-1:0] s_ht, s_hs, s_bs, s_bl, s_hbs, s_hbe;
    logic [VW-1:0] s_fh, s_vl;
    logic [OW-1:0] s_v1, s_v2, s_el, s_e1, s_e2;

    // Pack the programmed fields into one vector for the shadow.
    always_comb begin
        cfg_raw = {progressive, burst_on, equal_on,
                   h_total_m1, hsync_len, burst_start_m1, burst_len,
                   hblank_start_m1, hblank_end_m1,
                   field_half_m1, vsync_len,
                   vsync_start_f1_m1, vsync_start_f2_m1,
                   equal_len, equal_start_f1_m1, equal_start_f2_m1};
    end

    tv_cfg_shadow #(.W(CFG_W)) i_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_load),
        .cfg_in (cfg_raw),
        .cfg_q  (cfg_s)
    );

    // Split the snapshot back into its fields.
    always_comb begin
        {s_prog, s_burst_on, s_equal_on,
         s_ht, s_hs, s_bs, s_bl, s_hbs, s_hbe,
         s_fh, s_vl, s_v1, s_v2, s_el, s_e1, s_e2} = cfg_s;
    end

    tv_hcount #(.HW(HW)) i_hcount (
        .clk             (clk),
        .rst_n           (rst_n),
        .pix_en          (pix_en),
        .htotal_m1       (s_ht),
        .hs_len          (s_hs),
        .burst_on        (s_burst_on),
        .burst_start_m1  (s_bs),
        .burst_len       (s_bl),
        .hblank_start_m1 (s_hbs),
        .hblank_end_m1   (s_hbe),
        .pix_cnt         (pix_count),
        .half_pos        (half_pos),
        .half_tick       (half_tick),
        .hsync           (hsync),
        .hblank          (hblank),
        .burst_gate      (burst_gate)
    );

    tv_vcount #(.HW(HW), .VW(VW), .OW(OW)) i_vcount (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_tick     (half_tick),
        .prog          (s_prog),
        .equal_on      (s_equal_on),
        .field_half_m1 (s_fh),
        .vs_len        (s_vl),
        .vs_f1_m1      (s_v1),
        .vs_f2_m1      (s_v2),
        .eq_len        (s_el),
        .eq_f1_m1      (s_e1),
        .eq_f2_m1      (s_e2),
        .pix_cnt       (pix_count),
        .half_pos      (half_pos),
        .half_cnt      (half_count),
        .field_id      (field_id),
        .frame_load    (frame_load),
        .vsync         (vsync),
        .equal         (equal)
    );

    AST_HSYNC_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_count == '0 && s_hs != '0) |-> hsync); // R2
    AST_BURST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !s_burst_on |-> !burst_gate); // R3

endmodule

// File: tb/test_tv_timing_gen.sv
// Directed bench for tv_timing_gen. Time unit is the default picosecond
// step, so a 2500-step half period gives a 200 MHz clock.
module test_tv_timing_gen;

    localparam int HW = 13;
    localparam int VW = 11;
    localparam int OW = 7;
    localparam int HALF_PERIOD = 2500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic progressive = 1'b0;
    logic burst_on = 1'b1;
    logic equal_on = 1'b1;
    logic [HW-1:0] h_total_m1 = 13'd19;
    logic [HW-1:0] hsync_len = 13'd3;
    logic [HW-1:0] burst_start_m1 = 13'd4;
    logic [HW-1:0] burst_len = 13'd3;
    logic [HW-1:0] hblank_start_m1 = 13'd17;
    logic [HW-1:0] hblank_end_m1 = 13'd8;
    logic [VW-1:0] field_half_m1 = 11'd8;
    logic [VW-1:0] vsync_len = 11'd2;
    logic [OW-1:0] vsync_start_f1_m1 = 7'd0;
    logic [OW-1:0] vsync_start_f2_m1 = 7'd3;
    logic [OW-1:0] equal_len = 7'd1;
    logic [OW-1:0] equal_start_f1_m1 = 7'd5;
    logic [OW-1:0] equal_start_f2_m1 = 7'd6;

    logic hsync, hblank, burst_gate, vsync, equal, field_id;
    logic [HW-1:0] pix_count;
    logic [VW-1:0] half_count;

    int n_checks = 0;
    int n_fail = 0;
    int n_edges = 0;
    int cyc = 0;
    int hs_old = 3;
    int hs_new = 3;
    int sw_n = 1 << 30;

    tv_timing_gen #(.HW(HW), .VW(VW), .OW(OW)) i_tv_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .progressive(progressive),
        .burst_on(burst_on), .equal_on(equal_on), .h_total_m1(h_total_m1),
        .hsync_len(hsync_len), .burst_start_m1(burst_start_m1), .burst_len(burst_len),
        .hblank_start_m1(hblank_start_m1), .hblank_end_m1(hblank_end_m1),
        .field_half_m1(field_half_m1), .vsync_len(vsync_len),
        .vsync_start_f1_m1(vsync_start_f1_m1), .vsync_start_f2_m1(vsync_start_f2_m1),
        .equal_len(equal_len), .equal_start_f1_m1(equal_start_f1_m1),
        .equal_start_f2_m1(equal_start_f2_m1),
        .hsync(hsync), .hblank(hblank), .burst_gate(burst_gate), .vsync(vsync),
        .equal(equal), .field_id(field_id), .pix_count(pix_count), .half_count(half_count)
    );

    always #HALF_PERIOD clk = ~clk;

    // Bench-side count of enabled pixel edges since reset release.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) n_edges <= 0;
        else if (pix_en) n_edges <= n_edges + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, n_edges, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(HALF_PERIOD * 2 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Compare every output against values derived from the edge count.
    task automatic check_now();
        int t, ht, f, h, v, fidx, fld, vs, es, hs;
        t = int'(h_total_m1) + 1;
        ht = t / 2;
        f = int'(field_half_m1) + 1;
        h = n_edges % t;
        v = (n_edges / ht) % f;
        fidx = n_edges / (ht * f);
        fld = progressive ? 0 : fidx % 2;
        hs = (n_edges >= sw_n) ? hs_new : hs_old;
        vs = fld ? int'(vsync_start_f2_m1) : int'(vsync_start_f1_m1);
        es = fld ? int'(equal_start_f2_m1) : int'(equal_start_f1_m1);
        check("R1", "pix_count", int'(pix_count), h);
        check("R2", "hsync", int'(hsync), int'(h < hs));
        check("R3", "burst_gate", int'(burst_gate),
              int'(burst_on && h >= int'(burst_start_m1) + 1 &&
                   h < int'(burst_start_m1) + 1 + int'(burst_len)));
        check("R4", "hblank", int'(hblank),
              int'(!(h >= int'(hblank_end_m1) + 1 && h < int'(hblank_start_m1) + 1)));
        check("R5", "half_count", int'(half_count), v);
        check(progressive ? "R9" : "R8", "field_id", int'(field_id), fld);
        check("R6", "vsync", int'(vsync), int'(v >= vs + 1 && v < vs + 1 + int'(vsync_len)));
        check("R7", "equal", int'(equal),
              int'(equal_on && v >= es + 1 && v < es + 1 + int'(equal_len)));
    endtask

    // Run until the edge count reaches a target, checking at every falling edge.
    task automatic sweep(input int upto, input bit gated);
        while (n_edges < upto) begin
            @(negedge clk);
            check_now();
            pix_en = gated ? (cyc % 3 != 1) : 1'b1;
        end
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pix_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R11: counters cleared while reset is held, even after running.
    task automatic t_reset_state();
        do_reset();
        pix_en = 1'b1;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "pix_count in reset", int'(pix_count), 0);
        check("R11", "half_count in reset", int'(half_count), 0);
        check("R11", "field_id in reset", int'(field_id), 0);
        pix_en = 1'b0;
    endtask

    // R1 to R8: interlaced sweep over two frames.
    task automatic t_interlaced();
        progressive = 1'b0; burst_on = 1'b1; equal_on = 1'b1;
        do_reset();
        sweep(400, 1'b0);
    endtask

    // R1: gated pixel enable holds the counter between enabled edges.
    task automatic t_gated();
        do_reset();
        sweep(250, 1'b1);
    endtask

    // R3, R7: burst and equalization disabled.
    task automatic t_disabled();
        burst_on = 1'b0; equal_on = 1'b0;
        do_reset();
        sweep(200, 1'b0);
        burst_on = 1'b1; equal_on = 1'b1;
    endtask

    // R9: progressive scan keeps field 1 offsets throughout.
    task automatic t_progressive();
        progressive = 1'b1;
        do_reset();
        sweep(300, 1'b0);
        progressive = 1'b0;
    endtask

    // R10: a sync width change mid-frame waits for the frame start at edge 180.
    task automatic t_shadow();
        hsync_len = 13'd3; hs_old = 3; hs_new = 6; sw_n = 1 << 30;
        do_reset();
        sweep(50, 1'b0);
        hsync_len = 13'd6;
        sw_n = 180;
        pix_en = 1'b1;
        sweep(260, 1'b0);
        hsync_len = 13'd3; hs_old = 3; hs_new = 3; sw_n = 1 << 30;
    endtask

    initial begin
        t_reset_state();
        t_interlaced();
        t_gated();
        t_disabled();
        t_progressive();
        t_shadow();
        finish_run();
    end

endmodule